// File: doc/BRIEF.md
# Transmit Ring Halt Controller

This block holds one halt flag per transmit descriptor ring for a DMA engine that serves several rings (three by default). Each cycle at most one ring reports the outcome of a descriptor fetch: a valid strobe and four flags. The flags are ready, zero length, bad address and uncorrectable read error. From these the block decides whether the fetch was clean, found the ring empty, or hit a transmit error.

An empty ring halts only the ring that was fetched. A transmit error pulses an error event and halts every ring, including rings whose queue enable is low. Software reads the halt vector and releases rings by writing ones to their bit positions. Per ring, the block also drives a DMA permission that is the queue enable, masked by that ring's halt flag and by the global graceful-stop request. The graceful-stop request never sets a halt flag.

Top module: `txh_ctrl`

## Requirements
- R1: Reset drives every halt flag and the error event to 0. After reset, dma_allowed equals queue_en while graceful_stop is low.
- R2: A fetch with valid=1, ready=0 and both error flags at 0 is an empty fetch. On the next clock edge it sets only halt_vec bit r, where r is the ring index (bit 0 for ring 0, bit 1 for ring 1, bit 2 for ring 2).
- R3: A fetch with valid=1 and addr_bad=1 is a transmit error. On the next edge it sets all halt bits, and tx_err_event is 1 for exactly that one cycle.
- R4: A fetch with valid=1 and ecc_bad=1 is a transmit error with the same effect as R3.
- R5: A fetch with valid=1, ready=1 and zero_len=1 is a transmit error. A fetch with ready=0 and zero_len=1 and no error flag counts as empty (R2), not as an error.
- R6: A transmit error halts every ring whatever the value of queue_en.
- R7: A register write with reg_wr_en=1 clears each halt bit whose reg_wdata bit is 1. Bits written with 0 keep their value.
- R8: If a halt set and a write-1 clear reach the same bit in the same cycle, the bit ends up set.
- R9: graceful_stop never sets a halt bit.
- R10: dma_allowed[r] is 1 exactly when queue_en[r]=1, halt_vec[r]=0 and graceful_stop=0.
- R11: A clean fetch (valid=1, ready=1, zero_len=0, no error flag) changes no halt bit and raises no event.
- R12: A halt bit stays set until it is cleared by a write or by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | NUM_RINGS | Fetch result strobe per ring, at most one high |
| fetch_ready | input | NUM_RINGS | Fetched descriptor has its ready flag set |
| fetch_zero_len | input | NUM_RINGS | Fetched descriptor length is zero |
| fetch_addr_bad | input | NUM_RINGS | Descriptor or data address was invalid |
| fetch_ecc_bad | input | NUM_RINGS | Uncorrectable error on descriptor or data read |
| queue_en | input | NUM_RINGS | Per-ring queue enable |
| graceful_stop | input | 1 | Global graceful transmit stop request |
| reg_wr_en | input | 1 | Halt register write strobe |
| reg_wdata | input | NUM_RINGS | Write-one-to-clear mask |
| halt_vec | output | NUM_RINGS | Halt flags, bit r for ring r |
| tx_err_event | output | 1 | One-cycle transmit error event |
| dma_allowed | output | NUM_RINGS | Per-ring DMA permission |

## Verification
The hardest case to reach is a halt set landing on a bit in the same cycle as a software clear of that bit. The bench creates it by driving an empty or faulty fetch and a write of all ones on the same clock edge. It then checks that the set wins. Clearing partial halt patterns is also hard to reach, because the error path always sets every bit. To build each of the eight patterns, the bench issues empty fetches to chosen rings and then applies every write mask to each pattern.

// File: rtl/txh_pkg.sv
package txh_pkg;

    localparam int NUM_RINGS_DFLT = 3;

    typedef struct packed {
        logic valid;
        logic ready;
        logic zero_len;
        logic addr_bad;
        logic ecc_bad;
    } fetch_t;

    typedef enum logic [1:0] {
        FETCH_NONE  = 2'd0,
        FETCH_CLEAN = 2'd1,
        FETCH_EMPTY = 2'd2,
        FETCH_ERROR = 2'd3
    } fetch_kind_e;

    // Error conditions take priority over the empty-ring condition.
    function automatic fetch_kind_e classify(input fetch_t f);
        if (!f.valid)
            return FETCH_NONE;
        else if (f.addr_bad || f.ecc_bad || (f.ready && f.zero_len))
            return FETCH_ERROR;
        else if (!f.ready)
            return FETCH_EMPTY;
        else
            return FETCH_CLEAN;
    endfunction

endpackage

// File: rtl/txh_classify.sv
module txh_classify
    import txh_pkg::*;
#(
    parameter int NUM_RINGS = NUM_RINGS_DFLT
) (
    input  fetch_t               fetch [NUM_RINGS],
    output logic [NUM_RINGS-1:0] err_hit,
    output logic [NUM_RINGS-1:0] empty_hit
);
    for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
        fetch_kind_e kind;
        assign kind         = classify(fetch[r]);
        assign err_hit[r]   = (kind == FETCH_ERROR);
        assign empty_hit[r] = (kind == FETCH_EMPTY);
    end
endmodule

// File: rtl/txh_status.sv
module txh_status #(
    parameter int NUM_RINGS = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_RINGS-1:0] set_mask,
    input  logic [NUM_RINGS-1:0] clr_mask,
    input  logic                 err_any,
    output logic [NUM_RINGS-1:0] halt_q,
    output logic                 err_evt_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q    <= '0;
            err_evt_q <= 1'b0;
        end else begin
            // A set in the same cycle overrides a software clear.
            halt_q    <= (halt_q & ~clr_mask) | set_mask;
            err_evt_q <= err_any;
        end
    end
endmodule

// File: rtl/txh_ctrl.sv
module txh_ctrl
    import txh_pkg::*;
#(
    parameter int NUM_RINGS = NUM_RINGS_DFLT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_RINGS-1:0] fetch_valid,
    input  logic [NUM_RINGS-1:0] fetch_ready,
    input  logic [NUM_RINGS-1:0] fetch_zero_len,
    input  logic [NUM_RINGS-1:0] fetch_addr_bad,
    input  logic [NUM_RINGS-1:0] fetch_ecc_bad,
    input  logic [NUM_RINGS-1:0] queue_en,
    input  logic                 graceful_stop,
    input  logic                 reg_wr_en,
    input  logic [NUM_RINGS-1:0] reg_wdata,
    output logic [NUM_RINGS-1:0] halt_vec,
    output logic                 tx_err_event,
    output logic [NUM_RINGS-1:0] dma_allowed
);
    localparam logic [NUM_RINGS-1:0] ALL_RINGS = {NUM_RINGS{1'b1}};

    fetch_t               fetch [NUM_RINGS];
    logic [NUM_RINGS-1:0] err_hit;
    logic [NUM_RINGS-1:0] empty_hit;
    logic                 err_any;
    logic [NUM_RINGS-1:0] set_mask;
    logic [NUM_RINGS-1:0] clr_mask;

    for (genvar r = 0; r < NUM_RINGS; r++) begin : g_pack
        assign fetch[r] = '{valid:    fetch_valid[r],
                            ready:    fetch_ready[r],
                            zero_len: fetch_zero_len[r],
                            addr_bad: fetch_addr_bad[r],
                            ecc_bad:  fetch_ecc_bad[r]};
    end

    txh_classify #(.NUM_RINGS(NUM_RINGS)) u_classify (
        .fetch     (fetch),
        .err_hit   (err_hit),
        .empty_hit (empty_hit)
    );

    assign err_any  = |err_hit;
    assign set_mask = err_any ? ALL_RINGS : empty_hit;
    assign clr_mask = reg_wr_en ? reg_wdata : '0;

    txh_status #(.NUM_RINGS(NUM_RINGS)) u_status (
        .clk       (clk),
        .rst       (rst),
        .set_mask  (set_mask),
        .clr_mask  (clr_mask),
        .err_any   (err_any),
        .halt_q    (halt_vec),
        .err_evt_q (tx_err_event)
    );

    assign dma_allowed = queue_en & ~halt_vec & ~{NUM_RINGS{graceful_stop}};
endmodule

// File: rtl/txh_ctrl_chk.sv
module txh_ctrl_chk #(
    parameter int NUM_RINGS = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_RINGS-1:0] fetch_valid,
    input logic [NUM_RINGS-1:0] fetch_ready,
    input logic [NUM_RINGS-1:0] fetch_zero_len,
    input logic [NUM_RINGS-1:0] fetch_addr_bad,
    input logic [NUM_RINGS-1:0] fetch_ecc_bad,
    input logic [NUM_RINGS-1:0] queue_en,
    input logic                 graceful_stop,
    input logic                 reg_wr_en,
    input logic [NUM_RINGS-1:0] reg_wdata,
    input logic [NUM_RINGS-1:0] halt_vec,
    input logic                 tx_err_event,
    input logic [NUM_RINGS-1:0] dma_allowed
);
    logic [NUM_RINGS-1:0] bad;
    logic [NUM_RINGS-1:0] empty;
    logic                 any_bad;

    assign bad     = fetch_valid & (fetch_addr_bad | fetch_ecc_bad | (fetch_ready & fetch_zero_len));
    assign empty   = fetch_valid & ~fetch_ready & ~fetch_addr_bad & ~fetch_ecc_bad;
    assign any_bad = |bad;

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (halt_vec == '0 && !tx_err_event));

    assert_error_halts_all_R3: assert property (@(posedge clk) disable iff (rst)
        any_bad |=> (&halt_vec && tx_err_event));

    assert_event_single_R3: assert property (@(posedge clk) disable iff (rst)
        (tx_err_event && !any_bad) |=> !tx_err_event);

    for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
        assert_empty_sets_R2: assert property (@(posedge clk) disable iff (rst)
            empty[r] |=> halt_vec[r]);

        assert_w1c_only_R7: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $fell(halt_vec[r])) |-> $past(reg_wr_en && reg_wdata[r]));

        assert_rise_has_cause_R9: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $rose(halt_vec[r])) |-> $past(empty[r] || any_bad));

        assert_halt_blocks_dma_R10: assert property (@(posedge clk) disable iff (rst)
            halt_vec[r] |-> !dma_allowed[r]);
    end
endmodule

bind txh_ctrl txh_ctrl_chk #(.NUM_RINGS(NUM_RINGS)) u_chk (.*);

// File: tb/txh_ctrl_tb.sv
module txh_ctrl_tb;
    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] fetch_valid = '0, fetch_ready = '0, fetch_zero_len = '0;
    logic [N-1:0] fetch_addr_bad = '0, fetch_ecc_bad = '0, queue_en = '0;
    logic         graceful_stop = 1'b0, reg_wr_en = 1'b0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] halt_vec, dma_allowed;
    logic         tx_err_event;

    int vectors = 0;
    int errors  = 0;

    always #4 clk = ~clk;

    txh_ctrl #(.NUM_RINGS(N)) u_dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        fetch_valid = '0; fetch_ready = '0; fetch_zero_len = '0;
        fetch_addr_bad = '0; fetch_ecc_bad = '0;
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic clear_all();
        idle();
        reg_wr_en = 1'b1; reg_wdata = '1;
        @(negedge clk);
        idle();
    endtask

    task automatic empty_fetch(input int r);
        idle();
        fetch_valid[r] = 1'b1;
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        queue_en = 3'b101;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: state after reset
        chk("R1 halt", int'(halt_vec), 0);
        chk("R1 event", int'(tx_err_event), 0);
        chk("R1 dma", int'(dma_allowed), 5);

        // Fetch outcome sweep: every ring, every flag combination
        for (int r = 0; r < N; r++) begin
            for (int f = 0; f < 16; f++) begin
                bit rdy, zl, ab, eb, err, emp;
                int exp_h, q;
                rdy = f[0]; zl = f[1]; ab = f[2]; eb = f[3];
                err = ab | eb | (rdy & zl);
                emp = !err && !rdy;
                exp_h = err ? 7 : (emp ? (1 << r) : 0);
                q = (f ^ r) & 7;
                clear_all();
                queue_en = q[N-1:0];
                fetch_valid[r] = 1'b1; fetch_ready[r] = rdy; fetch_zero_len[r] = zl;
                fetch_addr_bad[r] = ab; fetch_ecc_bad[r] = eb;
                @(negedge clk);
                idle();
                // R2, R3, R4, R5, R6, R11 by flag combination
                if (err)      chk(ab ? "R3 halt" : (eb ? "R4 halt" : "R5 halt"), int'(halt_vec), exp_h);
                else if (emp) chk(zl ? "R5 empty" : "R2 halt", int'(halt_vec), exp_h);
                else          chk("R11 halt", int'(halt_vec), exp_h);
                chk(err ? "R6 event" : "R11 event", int'(tx_err_event), int'(err));
                chk("R10 dma", int'(dma_allowed), q & ~exp_h & 7);
                @(negedge clk);
                chk("R3 pulse", int'(tx_err_event), 0);
                chk("R12 hold", int'(halt_vec), exp_h);
            end
        end

        // Write-one-to-clear sweep over all patterns and masks
        for (int s = 0; s < 8; s++) begin
            for (int w = 0; w < 8; w++) begin
                clear_all();
                for (int r = 0; r < N; r++) if (s[r]) empty_fetch(r);
                chk("R12 pattern", int'(halt_vec), s);
                reg_wr_en = 1'b1; reg_wdata = w[N-1:0];
                @(negedge clk);
                idle();
                chk("R7 clear", int'(halt_vec), s & ~w & 7);
            end
        end

        // R8: set and clear collide
        clear_all();
        fetch_valid[1] = 1'b1; reg_wr_en = 1'b1; reg_wdata = '1;
        @(negedge clk);
        idle();
        chk("R8 empty vs clear", int'(halt_vec), 2);
        clear_all();
        fetch_valid[2] = 1'b1; fetch_ecc_bad[2] = 1'b1; reg_wr_en = 1'b1; reg_wdata = '1;
        @(negedge clk);
        idle();
        chk("R8 error vs clear", int'(halt_vec), 7);

        // R9: graceful stop sets nothing
        clear_all();
        queue_en = '1; graceful_stop = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 halt", int'(halt_vec), 0);
        chk("R9 dma", int'(dma_allowed), 0);
        graceful_stop = 1'b0;
        @(negedge clk);
        chk("R9 released", int'(halt_vec), 0);

        // R10: permission sweep
        for (int s = 0; s < 8; s++) begin
            clear_all();
            for (int r = 0; r < N; r++) if (s[r]) empty_fetch(r);
            for (int q = 0; q < 8; q++) begin
                for (int g = 0; g < 2; g++) begin
                    queue_en = q[N-1:0]; graceful_stop = g[0];
                    #1;
                    chk("R10 sweep", int'(dma_allowed), g ? 0 : (q & ~s & 7));
                end
            end
            graceful_stop = 1'b0;
        end

        // R1: reset mid-run
        fetch_valid[0] = 1'b1; fetch_addr_bad[0] = 1'b1;
        @(negedge clk);
        idle();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 midrun halt", int'(halt_vec), 0);
        chk("R1 midrun event", int'(tx_err_event), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule